// File: doc/BRIEF.md
# Burst Readout Sequencer with Byte-Sum Checksum

This block sits beside a 16-bit SPI slave. The slave's shift register reports each finished frame as a received word and a one-cycle strobe. The sequencer watches that frame stream while chip select is low. When the received word is the burst command 0x6800, it freezes one coherent copy of the sensor outputs. From then on it supplies the word that the shifter loads for each next frame. It advances one word per frame, so the host can clock the whole record back to back without stall gaps.

Three configuration bits, sampled with the snapshot, select the record layout:
- `cfg_wide` selects one 16-bit word per axis, or a low/high pair per axis.
- `cfg_delta` selects angular-rate and acceleration values, or delta-angle and delta-velocity values.
- `cfg_tstamp` selects whether the last data word is the time stamp or the sample counter.

These bits give eight record formats of 10 or 16 words. The final word is a 16-bit checksum: the plain unsigned sum of every byte of every earlier word. After the checksum the block returns 0x0000. Raising chip select ends the burst, and the slave's ordinary command decoding takes over again.

Top module: `burst_readout_seq`

## Requirements
- R1: A burst starts only when a frame strobe arrives with `cs_n` low, no burst active, and a received word of exactly 0x6800. Any other word, or any frame with `cs_n` high, leaves `burst_act` low.
- R2: The cycle after the command frame, `burst_act` is 1 and `tx_word` holds the status word. Each later frame strobe with `cs_n` low advances the record by exactly one word, and nothing else advances it.
- R3: With `cfg_wide`=0 and `cfg_delta`=0, the record is: status, rate X/Y/Z high halves (bits 31:16), acceleration X/Y/Z high halves, temperature, tail word, checksum. That is 10 words.
- R4: With `cfg_wide`=0 and `cfg_delta`=1, the six sensor slots of R3 carry the high halves of delta-angle X/Y/Z and then delta-velocity X/Y/Z.
- R5: With `cfg_wide`=1, each of the six sensor values takes two consecutive slots: bits 15:0 first, then bits 31:16. This gives 16 words in total. The sensor set still follows `cfg_delta`.
- R6: The checksum word equals the 16-bit sum of the high byte and the low byte of every earlier word in the record, each byte taken as unsigned.
- R7: The tail word (the one just before the checksum) is `tstamp_v` when `cfg_tstamp`=1, and `cnt_v` otherwise.
- R8: All sensor values and all three configuration bits are captured at the command frame. Changes to them during the burst do not alter any word of that record, and `tx_word` holds steady between frame strobes.
- R9: Every frame clocked after the checksum returns 0x0000 while `cs_n` stays low.
- R10: `cs_n` high ends the burst by the next cycle, with `burst_act`=0 and `tx_word`=0. A 0x6800 received inside a burst is treated as a filler frame, and a new burst after `cs_n` high starts cleanly.
- R11: During and after reset, `burst_act` is 0 and `tx_word` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select from the SPI slave, active low |
| frm_stb | input | 1 | One-cycle pulse: a 16-bit frame has completed |
| frm_rx | input | DW | Word received in the completed frame |
| cfg_wide | input | 1 | 1: low/high pair per axis; 0: high half only |
| cfg_delta | input | 1 | 1: delta-angle/velocity set; 0: rate/acceleration set |
| cfg_tstamp | input | 1 | 1: tail word is time stamp; 0: sample counter |
| st_word | input | DW | Status word |
| gyro_v | input | AXES*2*DW | Angular-rate values, axis k at bits k*32 upward |
| accl_v | input | AXES*2*DW | Acceleration values, same packing |
| dang_v | input | AXES*2*DW | Delta-angle values, same packing |
| dvel_v | input | AXES*2*DW | Delta-velocity values, same packing |
| temp_v | input | DW | Temperature word |
| cnt_v | input | DW | Sample counter |
| tstamp_v | input | DW | Time stamp |
| burst_act | output | 1 | Burst in progress; slave must load `tx_word` |
| tx_word | output | DW | Word to shift out on the next frame |

## Verification
Several properties are checked on every clock:
- the exact start condition and its refusal for any other word;
- the single-step advance per frame;
- the stability of `tx_word` between strobes, even while the sensor inputs move;
- the zero padding past the end of the record;
- the zero idle output and the end of the burst on chip select.

Only the bench scenarios can show the content of a record. These cover slot order in all eight formats, the low-before-high placement, the tail choice, the checksum value with all-zero and all-ones data, and the use of the frozen values after the inputs are scrambled mid-burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    SLOT_STAT,
    SLOT_SENS,
    SLOT_TEMP,
    SLOT_TAIL,
    SLOT_CSUM,
    SLOT_PAD
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [7:0] sens;   // sensor value number, rate/accel or delta set
    logic       upper;  // 1: bits 31:16 of the value
  } slot_t;

  // Map a record position to its content for a given layout.
  function automatic slot_t decode_slot(input int unsigned idx,
                                        input logic        wide,
                                        input int unsigned axes);
    int unsigned nsens;
    int unsigned span;
    int unsigned rel;
    slot_t       s;
    nsens   = 2 * axes;
    span    = wide ? 2 * nsens : nsens;
    rel     = 0;
    s.kind  = SLOT_PAD;
    s.sens  = '0;
    s.upper = 1'b1;
    if (idx == 0) begin
      s.kind = SLOT_STAT;
    end else if (idx <= span) begin
      rel    = idx - 1;
      s.kind = SLOT_SENS;
      if (wide) begin
        s.sens  = 8'(rel / 2);
        s.upper = ((rel % 2) == 1);
      end else begin
        s.sens  = 8'(rel);
        s.upper = 1'b1;
      end
    end else if (idx == span + 1) begin
      s.kind = SLOT_TEMP;
    end else if (idx == span + 2) begin
      s.kind = SLOT_TAIL;
    end else if (idx == span + 3) begin
      s.kind = SLOT_CSUM;
    end
    return s;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int          AXES = 3,
  parameter int          DW   = 16,
  parameter logic [15:0] CMD  = 16'h6800,
  localparam int LEN_N = 2 * AXES + 4,
  localparam int LEN_W = 4 * AXES + 4,
  localparam int IDX_W = $clog2(LEN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             frm_stb,
  input  logic [DW-1:0]    frm_rx,
  input  logic             wide_q,
  output logic             act_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             start,
  output logic             adv
);

  logic             act_d;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] last_idx;

  assign start    = frm_stb & ~cs_n & ~act_q & (frm_rx == DW'(CMD));
  assign adv      = frm_stb & ~cs_n & act_q;
  assign last_idx = wide_q ? IDX_W'(LEN_W) : IDX_W'(LEN_N);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (cs_n) begin
      act_d = 1'b0;
      idx_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (adv && (idx_q != last_idx)) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/burst_snap.sv
module burst_snap #(
  parameter int AXES = 3,
  parameter int DW   = 16,
  localparam int SW  = 2 * DW,
  localparam int NS  = 2 * AXES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               cfg_wide,
  input  logic               cfg_delta,
  input  logic               cfg_tstamp,
  input  logic [DW-1:0]      st_word,
  input  logic [AXES*SW-1:0] gyro_v,
  input  logic [AXES*SW-1:0] accl_v,
  input  logic [AXES*SW-1:0] dang_v,
  input  logic [AXES*SW-1:0] dvel_v,
  input  logic [DW-1:0]      temp_v,
  input  logic [DW-1:0]      cnt_v,
  input  logic [DW-1:0]      tstamp_v,
  output logic               wide_q,
  output logic [DW-1:0]      st_q,
  output logic [NS*SW-1:0]   sens_q,
  output logic [DW-1:0]      temp_q,
  output logic [DW-1:0]      tail_q
);

  logic             wide_d;
  logic [DW-1:0]    st_d;
  logic [DW-1:0]    temp_d;
  logic [DW-1:0]    tail_d;
  logic [NS*SW-1:0] sens_pick;
  logic [NS*SW-1:0] sens_d;

  // Only the set chosen by cfg_delta is stored: rotation slots first.
  for (genvar k = 0; k < AXES; k++) begin : g_axis
    assign sens_pick[k*SW +: SW]        = cfg_delta ? dang_v[k*SW +: SW] : gyro_v[k*SW +: SW];
    assign sens_pick[(AXES+k)*SW +: SW] = cfg_delta ? dvel_v[k*SW +: SW] : accl_v[k*SW +: SW];
  end

  always_comb begin
    wide_d = load ? cfg_wide  : wide_q;
    st_d   = load ? st_word   : st_q;
    temp_d = load ? temp_v    : temp_q;
    tail_d = load ? (cfg_tstamp ? tstamp_v : cnt_v) : tail_q;
    sens_d = load ? sens_pick : sens_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      st_q   <= '0;
      temp_q <= '0;
      tail_q <= '0;
      sens_q <= '0;
    end else begin
      wide_q <= wide_d;
      st_q   <= st_d;
      temp_q <= temp_d;
      tail_q <= tail_d;
      sens_q <= sens_d;
    end
  end

endmodule

// File: rtl/burst_csum.sv
module burst_csum #(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] sum_q
);

  logic [DW-1:0] sum_d;
  logic [DW-1:0] word_bytes;

  always_comb begin
    word_bytes = '0;
    for (int b = 0; b < NB; b++) begin
      word_bytes = word_bytes + DW'(word[b*8 +: 8]);
    end
  end

  always_comb begin
    sum_d = sum_q;
    if (clr) begin
      sum_d = '0;
    end else if (add) begin
      sum_d = sum_q + word_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

endmodule

// File: rtl/burst_word_mux.sv
module burst_word_mux
  import burst_pkg::*;
#(
  parameter int AXES = 3,
  parameter int DW   = 16,
  localparam int SW  = 2 * DW,
  localparam int NS  = 2 * AXES,
  localparam int NH  = 2 * NS,
  localparam int HW  = $clog2(NH)
) (
  input  logic             act,
  input  slot_t            slot,
  input  logic [DW-1:0]    st_q,
  input  logic [NS*SW-1:0] sens_q,
  input  logic [DW-1:0]    temp_q,
  input  logic [DW-1:0]    tail_q,
  input  logic [DW-1:0]    sum_q,
  output logic [DW-1:0]    word
);

  logic [DW-1:0] half_w [NH];
  logic [HW-1:0] hsel;

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign half_w[h] = sens_q[h*DW +: DW];
  end

  assign hsel = HW'({slot.sens, slot.upper});

  always_comb begin
    word = '0;
    if (act) begin
      unique case (slot.kind)
        SLOT_STAT: word = st_q;
        SLOT_SENS: word = half_w[hsel];
        SLOT_TEMP: word = temp_q;
        SLOT_TAIL: word = tail_q;
        SLOT_CSUM: word = sum_q;
        default:   word = '0;
      endcase
    end
  end

endmodule

// File: rtl/burst_readout_seq.sv
module burst_readout_seq
  import burst_pkg::*;
#(
  parameter int          AXES = 3,
  parameter int          DW   = 16,
  parameter logic [15:0] CMD  = 16'h6800,
  localparam int SW    = 2 * DW,
  localparam int NS    = 2 * AXES,
  localparam int LEN_W = 4 * AXES + 4,
  localparam int IDX_W = $clog2(LEN_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               frm_stb,
  input  logic [DW-1:0]      frm_rx,
  input  logic               cfg_wide,
  input  logic               cfg_delta,
  input  logic               cfg_tstamp,
  input  logic [DW-1:0]      st_word,
  input  logic [AXES*SW-1:0] gyro_v,
  input  logic [AXES*SW-1:0] accl_v,
  input  logic [AXES*SW-1:0] dang_v,
  input  logic [AXES*SW-1:0] dvel_v,
  input  logic [DW-1:0]      temp_v,
  input  logic [DW-1:0]      cnt_v,
  input  logic [DW-1:0]      tstamp_v,
  output logic               burst_act,
  output logic [DW-1:0]      tx_word
);

  logic [1:0]       rst_sync;
  logic             rst_q;
  logic             act_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;
  logic             adv;
  logic             wide_q;
  logic [DW-1:0]    st_q;
  logic [NS*SW-1:0] sens_q;
  logic [DW-1:0]    temp_q;
  logic [DW-1:0]    tail_q;
  logic [DW-1:0]    sum_q;
  logic             sum_add;
  slot_t            slot;

  // Assert asynchronously, release two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  burst_ctrl #(.AXES(AXES), .DW(DW), .CMD(CMD)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q),
    .cs_n    (cs_n),
    .frm_stb (frm_stb),
    .frm_rx  (frm_rx),
    .wide_q  (wide_q),
    .act_q   (act_q),
    .idx_q   (idx_q),
    .start   (start),
    .adv     (adv)
  );

  burst_snap #(.AXES(AXES), .DW(DW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_q),
    .load       (start),
    .cfg_wide   (cfg_wide),
    .cfg_delta  (cfg_delta),
    .cfg_tstamp (cfg_tstamp),
    .st_word    (st_word),
    .gyro_v     (gyro_v),
    .accl_v     (accl_v),
    .dang_v     (dang_v),
    .dvel_v     (dvel_v),
    .temp_v     (temp_v),
    .cnt_v      (cnt_v),
    .tstamp_v   (tstamp_v),
    .wide_q     (wide_q),
    .st_q       (st_q),
    .sens_q     (sens_q),
    .temp_q     (temp_q),
    .tail_q     (tail_q)
  );

  assign slot = decode_slot(32'(idx_q), wide_q, AXES);

  burst_word_mux #(.AXES(AXES), .DW(DW)) u_mux (
    .act    (act_q),
    .slot   (slot),
    .st_q   (st_q),
    .sens_q (sens_q),
    .temp_q (temp_q),
    .tail_q (tail_q),
    .sum_q  (sum_q),
    .word   (tx_word)
  );

  // Sum each data word as its frame goes out; stop at the checksum slot.
  assign sum_add = adv & (slot.kind != SLOT_CSUM) & (slot.kind != SLOT_PAD);

  burst_csum #(.DW(DW)) u_csum (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (start),
    .add   (sum_add),
    .word  (tx_word),
    .sum_q (sum_q)
  );

  assign burst_act = act_q;

endmodule

// File: rtl/burst_readout_chk.sv
module burst_readout_chk #(
  parameter int          AXES = 3,
  parameter int          DW   = 16,
  parameter logic [15:0] CMD  = 16'h6800,
  localparam int LEN_N = 2 * AXES + 4,
  localparam int LEN_W = 4 * AXES + 4,
  localparam int IDX_W = $clog2(LEN_W + 1)
) (
  input logic             clk,
  input logic             rst_q,
  input logic             cs_n,
  input logic             frm_stb,
  input logic [DW-1:0]    frm_rx,
  input logic             burst_act,
  input logic [DW-1:0]    tx_word,
  input logic [IDX_W-1:0] idx_q,
  input logic             wide_q
);

  logic [IDX_W-1:0] end_idx;
  assign end_idx = wide_q ? IDX_W'(LEN_W) : IDX_W'(LEN_N);

  p_start_cmd_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (frm_stb && !cs_n && !burst_act && frm_rx == DW'(CMD)) |=> (burst_act && idx_q == '0));

  p_no_false_start_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (!burst_act && !(frm_stb && !cs_n && frm_rx == DW'(CMD))) |=> !burst_act);

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (burst_act && frm_stb && !cs_n && idx_q != end_idx) |=> (idx_q == $past(idx_q) + 1'b1));

  p_hold_between_frames_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (burst_act && !cs_n && !frm_stb) |=> ($stable(tx_word) && $stable(idx_q) && burst_act));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (burst_act && idx_q == end_idx) |-> (tx_word == '0));

  p_cs_ends_r10: assert property (@(posedge clk) disable iff (!rst_q)
    cs_n |=> !burst_act);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !burst_act |-> (tx_word == '0));

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_q)
    idx_q <= IDX_W'(LEN_W));

endmodule

bind burst_readout_seq burst_readout_chk #(.AXES(AXES), .DW(DW), .CMD(CMD)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .cs_n      (cs_n),
  .frm_stb   (frm_stb),
  .frm_rx    (frm_rx),
  .burst_act (burst_act),
  .tx_word   (tx_word),
  .idx_q     (idx_q),
  .wide_q    (wide_q)
);

// File: tb/tb_burst_readout_seq.sv
`timescale 1ns/1ps
module tb_burst_readout_seq;
  localparam int          AXES = 3;
  localparam int          DW   = 16;
  localparam int          SW   = 32;
  localparam logic [15:0] CMD  = 16'h6800;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cs_n;
  logic               frm_stb;
  logic [DW-1:0]      frm_rx;
  logic               cfg_wide, cfg_delta, cfg_tstamp;
  logic [DW-1:0]      st_word, temp_v, cnt_v, tstamp_v;
  logic [AXES*SW-1:0] gyro_v, accl_v, dang_v, dvel_v;
  logic               burst_act;
  logic [DW-1:0]      tx_word;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [15:0] exp_w [16];
  int          exp_n;
  string       exp_tag [16];

  always #4 clk = ~clk;

  burst_readout_seq #(.AXES(AXES), .DW(DW), .CMD(CMD)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frm_stb(frm_stb), .frm_rx(frm_rx),
    .cfg_wide(cfg_wide), .cfg_delta(cfg_delta), .cfg_tstamp(cfg_tstamp),
    .st_word(st_word), .gyro_v(gyro_v), .accl_v(accl_v), .dang_v(dang_v),
    .dvel_v(dvel_v), .temp_v(temp_v), .cnt_v(cnt_v), .tstamp_v(tstamp_v),
    .burst_act(burst_act), .tx_word(tx_word)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic frame(input logic [15:0] w);
    @(negedge clk);
    frm_rx  = w;
    frm_stb = 1'b1;
    @(negedge clk);
    frm_stb = 1'b0;
    frm_rx  = '0;
  endtask

  function automatic logic [31:0] gen(input int seed, input int slot);
    if (seed == 100) return 32'hFFFF_FFFF;
    if (seed == 101) return 32'h0000_0000;
    return (32'(seed) * 32'h9E37_79B1) ^ (32'(slot + 1) * 32'h0100_0193) ^ 32'h5A5A_A5A5;
  endfunction

  task automatic load_inputs(input int seed);
    st_word  = gen(seed, 20)[15:0];
    temp_v   = gen(seed, 21)[31:16];
    cnt_v    = gen(seed, 22)[15:0];
    tstamp_v = gen(seed, 23)[23:8];
    for (int k = 0; k < AXES; k++) begin
      gyro_v[k*SW +: SW] = gen(seed, k);
      accl_v[k*SW +: SW] = gen(seed, 4 + k);
      dang_v[k*SW +: SW] = gen(seed, 8 + k);
      dvel_v[k*SW +: SW] = gen(seed, 12 + k);
    end
  endtask

  // Expected record computed from the layout rules alone.
  task automatic build_exp(input int m);
    bit          wide, delta, ts;
    logic [31:0] v;
    logic [15:0] s;
    int          span;
    wide  = m[0];
    delta = m[1];
    ts    = m[2];
    exp_n = wide ? 16 : 10;
    exp_w[0]   = st_word;
    exp_tag[0] = "R2 status";
    for (int k = 0; k < 2 * AXES; k++) begin
      if (k < AXES) v = delta ? dang_v[k*SW +: SW] : gyro_v[k*SW +: SW];
      else          v = delta ? dvel_v[(k-AXES)*SW +: SW] : accl_v[(k-AXES)*SW +: SW];
      if (wide) begin
        exp_w[1+2*k]   = v[15:0];
        exp_w[2+2*k]   = v[31:16];
        exp_tag[1+2*k] = "R5 low half";
        exp_tag[2+2*k] = "R5 high half";
      end else begin
        exp_w[1+k]   = v[31:16];
        exp_tag[1+k] = delta ? "R4 delta slot" : "R3 rate slot";
      end
    end
    span = wide ? 4 * AXES : 2 * AXES;
    exp_w[span+1]   = temp_v;
    exp_tag[span+1] = "R3 temperature";
    exp_w[span+2]   = ts ? tstamp_v : cnt_v;
    exp_tag[span+2] = "R7 tail";
    s = '0;
    for (int i = 0; i < exp_n - 1; i++) s = s + 16'(exp_w[i][15:8]) + 16'(exp_w[i][7:0]);
    exp_w[exp_n-1]   = s;
    exp_tag[exp_n-1] = "R6 checksum";
  endtask

  task automatic run_burst(input int seed, input int m);
    load_inputs(seed);
    cfg_wide   = m[0];
    cfg_delta  = m[1];
    cfg_tstamp = m[2];
    build_exp(m);
    @(negedge clk);
    cs_n = 1'b0;
    frame(CMD);
    chk({15'b0, burst_act}, 16'h0001, "R2 active");
    chk(tx_word, exp_w[0], exp_tag[0]);
    // Scramble every input after the snapshot.
    load_inputs(seed + 7);
    cfg_wide   = ~cfg_wide;
    cfg_delta  = ~cfg_delta;
    cfg_tstamp = ~cfg_tstamp;
    repeat (3) @(negedge clk);
    chk(tx_word, exp_w[0], "R8 hold without frame");
    for (int i = 1; i < exp_n; i++) begin
      frame((i == 2) ? CMD : 16'(i * 16'h1111));
      chk(tx_word, exp_w[i], (i == 2) ? "R10 command inside burst" : exp_tag[i]);
    end
    for (int p = 0; p < 2; p++) begin
      frame(16'h0000);
      chk(tx_word, 16'h0000, "R9 past checksum");
    end
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk({15'b0, burst_act}, 16'h0000, "R10 cs high ends");
    chk(tx_word, 16'h0000, "R10 idle word");
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; frm_stb = 1'b0; frm_rx = '0;
    cfg_wide = 1'b0; cfg_delta = 1'b0; cfg_tstamp = 1'b0;
    load_inputs(1);
    repeat (3) @(negedge clk);
    chk({15'b0, burst_act}, 16'h0000, "R11 act in reset");
    chk(tx_word, 16'h0000, "R11 word in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({15'b0, burst_act}, 16'h0000, "R11 act after reset");
    chk(tx_word, 16'h0000, "R11 word after reset");

    // R1: wrong word with select low, right word with select high.
    cs_n = 1'b0;
    frame(16'h6801);
    chk({15'b0, burst_act}, 16'h0000, "R1 other word");
    frame(16'hE800);
    chk({15'b0, burst_act}, 16'h0000, "R1 other word");
    cs_n = 1'b1;
    frame(CMD);
    chk({15'b0, burst_act}, 16'h0000, "R1 cs high");

    // R10: abort part way, then a clean restart.
    load_inputs(3);
    build_exp(0);
    cs_n = 1'b0;
    frame(CMD);
    frame(16'h0);
    frame(16'h0);
    chk(tx_word, exp_w[2], "R3 rate slot");
    cs_n = 1'b1;
    @(negedge clk);
    chk({15'b0, burst_act}, 16'h0000, "R10 abort");

    for (int m = 0; m < 8; m++) begin
      run_burst(100, m);
      run_burst(101, m);
      for (int s = 0; s < 4; s++) run_burst(s * 13 + m + 2, m);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule